// File: doc/BRIEF.md
# Interleaved Barrel Thread Issue Pipeline

This block is the front of a fine-grained multithreaded core. On every enabled clock cycle it issues the program counter of a different hardware thread. The threads take turns in a fixed round-robin order. Each issued slot enters a short pipeline of stage registers, and every stage carries a valid bit and the ID of the thread that owns its instruction. From each stage tag the block decodes a one-hot register-bank select. Downstream logic uses these selects to index replicated register files, so each stage reads or writes the bank of its own thread.

Every thread keeps a private program counter. That counter moves only when the thread actually issues, and only if the thread's advance request is set. A redirect input loads a new target into a thread's counter. The redirect takes priority over any advance in the same cycle, so the thread's next turn issues the target. While the enable input is low, the rotation freezes and invalid bubbles flow down the pipeline. When the stage count does not exceed the thread count, no two live stages ever belong to the same thread, so no forwarding between stages is needed.

Top module: `barrel_issue_top`

## Requirements
- R1: After a synchronous active-low reset, all stage valid bits and all bank selects are 0, and the first enabled cycle issues thread 0.
- R2: On successive enabled cycles the issuing thread ID steps 0, 1, …, NUM_THR-1 and then wraps to 0.
- R3: A cycle with `issue_en` low inserts a bubble (`iss_vld` = 0) and leaves the rotation where it was, so the next enabled cycle issues the thread that was due.
- R4: The valid bit and thread ID of stage k appear in stage k+1 one cycle later, for bubbles as well as for live slots. Stage 0 is the issue stage and drives `iss_vld`/`iss_tid`/`iss_pc`.
- R5: A thread's PC grows by PC_STEP (default 4) only at the edge where that thread issues with its `pc_adv` bit set. Other threads' PCs do not move.
- R6: A thread that issues with its `pc_adv` bit clear keeps its PC, so its next turn issues the same address.
- R7: A redirect (`redir_vld[t]` with target in `redir_pc[t*PC_W +: PC_W]`) loads the target at that edge, in any cycle. It beats a simultaneous advance, and the thread's next issue carries the target.
- R8: Thread t resets to PC t*RST_STRIDE (default 0x100, so 0x000, 0x100, 0x200, 0x300).
- R9: `stg_bank_sel[k*NUM_THR + t]` is 1 exactly when stage k is valid and holds thread t. An invalid stage drives all zeros.
- R10: With NUM_STG ≤ NUM_THR, no two valid stages ever hold the same thread ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_en | input | 1 | Issue enable; low inserts a bubble and freezes the rotation |
| pc_adv | input | NUM_THR | Per-thread request to step the PC when that thread issues |
| redir_vld | input | NUM_THR | Per-thread redirect strobe |
| redir_pc | input | NUM_THR*PC_W | Per-thread redirect targets, thread t at bits t*PC_W |
| iss_vld | output | 1 | Issue-stage slot is valid |
| iss_tid | output | TID_W | Thread ID of the issued slot |
| iss_pc | output | PC_W | PC of the issued slot |
| stg_vld | output | NUM_STG | Valid bit per stage |
| stg_tid | output | NUM_STG*TID_W | Thread ID tag per stage |
| stg_bank_sel | output | NUM_STG*NUM_THR | One-hot register-bank select per stage |

## Verification
A corrupted rotation counter shows up at the issue outputs on the next enabled cycle, as a wrong or repeated thread ID. A wrong per-thread PC stays hidden until that thread's next turn, at most NUM_THR enabled cycles later. A fault in the stage shift or in the tag decode appears as a stage tag or bank select that differs from the issue history k cycles back. If threads collide between stages, two valid stages show the same ID in the same cycle.

// File: rtl/barrel_pkg.sv
// Package: barrel_pkg
// Shared defaults and a helper for the barrel issue pipeline.
// Assumes: thread counts are at least 2, so thread IDs are at least 1 bit wide.
package barrel_pkg;

    localparam int DEF_NUM_THR   = 4;
    localparam int DEF_NUM_STG   = 4;
    localparam int DEF_PC_W      = 16;
    localparam int DEF_PC_STEP   = 4;
    localparam int DEF_RST_STRIDE = 'h100;

    // Width needed to hold an ID for n threads (at least one bit).
    function automatic int tid_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/barrel_rotor.sv
// Module: barrel_rotor
// Round-robin thread pointer. It names the thread that issues on the next
// enabled edge and steps once per enabled cycle, wrapping after the last thread.
// Assumes: NUM_THR >= 2; enable low freezes the pointer.
module barrel_rotor #(
    parameter int NUM_THR = barrel_pkg::DEF_NUM_THR,
    localparam int TID_W  = barrel_pkg::tid_width(NUM_THR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [TID_W-1:0] cur_tid
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THR - 1);

    logic [TID_W-1:0] nxt_tid;

    // Next pointer: wrap after the last thread, otherwise count up.
    always_comb begin
        if (cur_tid == LAST_TID) begin
            nxt_tid = '0;
        end else begin
            nxt_tid = cur_tid + TID_W'(1);
        end
    end

    // Pointer register: thread 0 after reset, steps only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tid <= '0;
        end else if (step_en) begin
            cur_tid <= nxt_tid;
        end
    end

    // R2: an enabled cycle moves the pointer by one, wrapping at the end.
    p_rot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (cur_tid == (($past(cur_tid) == LAST_TID) ? '0 : $past(cur_tid) + TID_W'(1))));

    // R3: a disabled cycle leaves the pointer untouched.
    p_rot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(cur_tid));

    // R2: the pointer never names a thread that does not exist.
    p_rot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_tid <= LAST_TID);

    // R1: reset puts thread 0 first.
    p_rot_reset_r1: assert property (@(posedge clk)
        !rst_n |=> cur_tid == '0);

endmodule

// File: rtl/barrel_pc_bank.sv
// Module: barrel_pc_bank
// One program counter per thread. A counter moves only when its thread issues
// with its advance bit set. A redirect loads a target in any cycle and wins
// over an advance. Also provides the PC of the thread whose turn it is.
// Assumes: redirect targets arrive packed, thread t at bits t*PC_W.
module barrel_pc_bank #(
    parameter int NUM_THR    = barrel_pkg::DEF_NUM_THR,
    parameter int PC_W       = barrel_pkg::DEF_PC_W,
    parameter int PC_STEP    = barrel_pkg::DEF_PC_STEP,
    parameter int RST_STRIDE = barrel_pkg::DEF_RST_STRIDE,
    localparam int TID_W     = barrel_pkg::tid_width(NUM_THR)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_en,
    input  logic [TID_W-1:0]        cur_tid,
    input  logic [NUM_THR-1:0]      pc_adv,
    input  logic [NUM_THR-1:0]      redir_vld,
    input  logic [NUM_THR*PC_W-1:0] redir_pc,
    output logic [PC_W-1:0]         cur_pc
);

    logic [PC_W-1:0]    pc_q [NUM_THR];
    logic [NUM_THR-1:0] turn;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        localparam logic [PC_W-1:0] RST_PC = PC_W'(t * RST_STRIDE);

        // Turn flag: this thread issues at the coming edge.
        assign turn[t] = issue_en && (cur_tid == TID_W'(t));

        // PC register: reset base, redirect first, then advance on own turn.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[t] <= RST_PC;
            end else if (redir_vld[t]) begin
                pc_q[t] <= redir_pc[t*PC_W +: PC_W];
            end else if (turn[t] && pc_adv[t]) begin
                pc_q[t] <= pc_q[t] + PC_W'(PC_STEP);
            end
        end

        // R5: an advancing turn moves the PC by exactly one step.
        p_pc_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (turn[t] && pc_adv[t] && !redir_vld[t]) |=> pc_q[t] == $past(pc_q[t]) + PC_W'(PC_STEP));

        // R5/R6: without a redirect or an advancing turn the PC holds.
        p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!redir_vld[t] && !(turn[t] && pc_adv[t])) |=> $stable(pc_q[t]));

        // R7: a redirect lands its target regardless of the thread's turn.
        p_pc_redir_r7: assert property (@(posedge clk) disable iff (!rst_n)
            redir_vld[t] |=> pc_q[t] == $past(redir_pc[t*PC_W +: PC_W]));

        // R8: reset restores this thread's base address.
        p_pc_reset_r8: assert property (@(posedge clk)
            !rst_n |=> pc_q[t] == RST_PC);
    end

    // Read port: PC of the thread named by the rotor.
    always_comb begin
        cur_pc = pc_q[0];
        for (int t = 1; t < NUM_THR; t++) begin
            if (cur_tid == TID_W'(t)) begin
                cur_pc = pc_q[t];
            end
        end
    end

endmodule

// File: rtl/barrel_tag_pipe.sv
// Module: barrel_tag_pipe
// Stage registers that carry a valid bit and thread ID with every slot.
// Stage 0 also holds the issued PC. Every stage decodes its tag into a
// one-hot register-bank select.
// Assumes: NUM_STG >= 1; a bubble enters stage 0 when issue is disabled.
module barrel_tag_pipe #(
    parameter int NUM_THR = barrel_pkg::DEF_NUM_THR,
    parameter int NUM_STG = barrel_pkg::DEF_NUM_STG,
    parameter int PC_W    = barrel_pkg::DEF_PC_W,
    localparam int TID_W  = barrel_pkg::tid_width(NUM_THR)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic [TID_W-1:0]           in_tid,
    input  logic [PC_W-1:0]            in_pc,
    output logic [PC_W-1:0]            s0_pc,
    output logic [NUM_STG-1:0]         stg_vld,
    output logic [NUM_STG*TID_W-1:0]   stg_tid,
    output logic [NUM_STG*NUM_THR-1:0] stg_bank_sel
);

    logic [NUM_STG-1:0] vld_q;
    logic [TID_W-1:0]   tid_q [NUM_STG];

    // Stage 0: capture the issued slot, or a bubble when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            tid_q[0] <= '0;
            s0_pc    <= '0;
        end else begin
            vld_q[0] <= in_vld;
            tid_q[0] <= in_tid;
            s0_pc    <= in_pc;
        end
    end

    for (genvar k = 1; k < NUM_STG; k++) begin : g_stg
        // Stage k: take the tag from stage k-1 unconditionally.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[k] <= 1'b0;
                tid_q[k] <= '0;
            end else begin
                vld_q[k] <= vld_q[k-1];
                tid_q[k] <= tid_q[k-1];
            end
        end

        // R4: the tag and valid bit move one stage per cycle.
        p_tag_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (vld_q[k] == $past(vld_q[k-1])) && (tid_q[k] == $past(tid_q[k-1])));
    end

    for (genvar k = 0; k < NUM_STG; k++) begin : g_out
        assign stg_tid[k*TID_W +: TID_W] = tid_q[k];
        for (genvar t = 0; t < NUM_THR; t++) begin : g_sel
            // Bank select: stage k is live and belongs to thread t.
            assign stg_bank_sel[k*NUM_THR + t] = vld_q[k] && (tid_q[k] == TID_W'(t));
        end

        // R9: a bank select is never active for an empty stage, and at most one fires.
        p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(stg_bank_sel[k*NUM_THR +: NUM_THR]) &&
            (vld_q[k] || (stg_bank_sel[k*NUM_THR +: NUM_THR] == '0)));
    end

    assign stg_vld = vld_q;

    // R1: reset clears every stage's valid bit.
    p_pipe_reset_r1: assert property (@(posedge clk)
        !rst_n |=> vld_q == '0);

    // R10: with no more stages than threads, live stages never share a thread.
    always_ff @(posedge clk) begin
        if (rst_n && (NUM_STG <= NUM_THR)) begin
            for (int a = 0; a < NUM_STG; a++) begin
                for (int b = a + 1; b < NUM_STG; b++) begin
                    p_tag_distinct_r10: assert (!(vld_q[a] && vld_q[b] && (tid_q[a] == tid_q[b])));
                end
            end
        end
    end

endmodule

// File: rtl/barrel_issue_top.sv
// Module: barrel_issue_top
// Interleaved barrel issue unit: one thread per enabled cycle in a fixed
// rotation, per-thread PCs, and a tagged stage pipeline with bank selects.
// Assumes: NUM_THR >= 2; a hazard-free stream needs NUM_STG <= NUM_THR.
module barrel_issue_top #(
    parameter int NUM_THR    = barrel_pkg::DEF_NUM_THR,
    parameter int NUM_STG    = barrel_pkg::DEF_NUM_STG,
    parameter int PC_W       = barrel_pkg::DEF_PC_W,
    parameter int PC_STEP    = barrel_pkg::DEF_PC_STEP,
    parameter int RST_STRIDE = barrel_pkg::DEF_RST_STRIDE,
    localparam int TID_W     = barrel_pkg::tid_width(NUM_THR)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue_en,
    input  logic [NUM_THR-1:0]         pc_adv,
    input  logic [NUM_THR-1:0]         redir_vld,
    input  logic [NUM_THR*PC_W-1:0]    redir_pc,
    output logic                       iss_vld,
    output logic [TID_W-1:0]           iss_tid,
    output logic [PC_W-1:0]            iss_pc,
    output logic [NUM_STG-1:0]         stg_vld,
    output logic [NUM_STG*TID_W-1:0]   stg_tid,
    output logic [NUM_STG*NUM_THR-1:0] stg_bank_sel
);

    logic [TID_W-1:0] cur_tid;
    logic [PC_W-1:0]  cur_pc;

    // Rotation pointer.
    barrel_rotor #(
        .NUM_THR (NUM_THR)
    ) u_rotor (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (issue_en),
        .cur_tid (cur_tid)
    );

    // Per-thread program counters.
    barrel_pc_bank #(
        .NUM_THR    (NUM_THR),
        .PC_W       (PC_W),
        .PC_STEP    (PC_STEP),
        .RST_STRIDE (RST_STRIDE)
    ) u_pcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_en  (issue_en),
        .cur_tid   (cur_tid),
        .pc_adv    (pc_adv),
        .redir_vld (redir_vld),
        .redir_pc  (redir_pc),
        .cur_pc    (cur_pc)
    );

    // Tagged stage pipeline.
    barrel_tag_pipe #(
        .NUM_THR (NUM_THR),
        .NUM_STG (NUM_STG),
        .PC_W    (PC_W)
    ) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_vld       (issue_en),
        .in_tid       (cur_tid),
        .in_pc        (cur_pc),
        .s0_pc        (iss_pc),
        .stg_vld      (stg_vld),
        .stg_tid      (stg_tid),
        .stg_bank_sel (stg_bank_sel)
    );

    assign iss_vld = stg_vld[0];
    assign iss_tid = stg_tid[TID_W-1:0];

    // R3: a disabled cycle yields a bubble at the issue stage.
    p_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_en |=> !iss_vld);

    // R2: two consecutive live issues never come from the same thread.
    p_issue_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && issue_en) |=> iss_tid != $past(iss_tid));

endmodule

// File: tb/barrel_issue_top_test.sv
// Bench: table of stimulus and expected issue results walked by one loop,
// with stage tags and bank selects checked against the issue history.
// Directed reset tests follow.
module barrel_issue_top_test;

    localparam int NT = 4;
    localparam int NS = 4;
    localparam int PW = 16;
    localparam int TW = 2;
    localparam int NV = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_en = 1'b0;
    logic [NT-1:0]   pc_adv = '0;
    logic [NT-1:0]   redir_vld = '0;
    logic [NT*PW-1:0] redir_pc = '0;
    logic            iss_vld;
    logic [TW-1:0]   iss_tid;
    logic [PW-1:0]   iss_pc;
    logic [NS-1:0]   stg_vld;
    logic [NS*TW-1:0] stg_tid;
    logic [NS*NT-1:0] stg_bank_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    barrel_issue_top uut (
        .clk(clk), .rst_n(rst_n), .issue_en(issue_en), .pc_adv(pc_adv),
        .redir_vld(redir_vld), .redir_pc(redir_pc), .iss_vld(iss_vld),
        .iss_tid(iss_tid), .iss_pc(iss_pc), .stg_vld(stg_vld),
        .stg_tid(stg_tid), .stg_bank_sel(stg_bank_sel)
    );

    // Fields: en | adv | redir | target | exp_vld | exp_tid | exp_pc
    localparam logic [43:0] VEC [NV] = '{
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd0, 16'h0000},  // R1 R8 first issue thread 0
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd1, 16'h0100},  // R2
        {1'b0, 4'hF, 4'h0, 16'h0000, 1'b0, 2'd0, 16'h0000},  // R3 bubble
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd2, 16'h0200},  // R3 rotation resumes
        {1'b1, 4'h0, 4'h0, 16'h0000, 1'b1, 2'd3, 16'h0300},  // R6 no advance
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd0, 16'h0004},  // R2 wrap, R5
        {1'b1, 4'hF, 4'h4, 16'h0AB0, 1'b1, 2'd1, 16'h0104},  // R7 redirect thread 2
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd2, 16'h0AB0},  // R7 target issued
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd3, 16'h0300},  // R6 held PC reissued
        {1'b1, 4'hF, 4'h1, 16'h0C00, 1'b1, 2'd0, 16'h0008},  // R7 redirect beats advance
        {1'b0, 4'hF, 4'h2, 16'h0D00, 1'b0, 2'd0, 16'h0000},  // R7 redirect during bubble
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd1, 16'h0D00},  // R7
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd2, 16'h0AB4},  // R5
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd3, 16'h0304},  // R5
        {1'b1, 4'hF, 4'h0, 16'h0000, 1'b1, 2'd0, 16'h0C00}   // R7
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // R1/R4/R9/R10 check of every stage against the expected history.
    task automatic chk_stages(input logic hv [NV], input logic [TW-1:0] ht [NV], input int i);
        for (int k = 0; k < NS; k++) begin
            logic ev;
            logic [TW-1:0] et;
            logic [NT-1:0] es;
            ev = (i - k >= 0) ? hv[i-k] : 1'b0;
            et = (i - k >= 0) ? ht[i-k] : '0;
            es = ev ? (NT'(1) << et) : '0;
            chk(stg_vld[k] == ev, "R4 stage valid", int'(stg_vld[k]), int'(ev));
            if (ev) chk(stg_tid[k*TW +: TW] == et, "R4 stage tid", int'(stg_tid[k*TW +: TW]), int'(et));
            chk(stg_bank_sel[k*NT +: NT] == es, "R9 bank select", int'(stg_bank_sel[k*NT +: NT]), int'(es));
        end
        for (int a = 0; a < NS; a++) begin
            for (int b = a + 1; b < NS; b++) begin
                chk(!(stg_vld[a] && stg_vld[b] && stg_tid[a*TW +: TW] == stg_tid[b*TW +: TW]),
                    "R10 distinct threads", int'(stg_tid[a*TW +: TW]), -1);
            end
        end
    endtask

    initial begin
        logic          hv [NV];
        logic [TW-1:0] ht [NV];
        rst_n = 1'b0;
        tick();
        tick();
        // R1: reset state at the ports.
        chk(stg_vld == '0, "R1 reset valid", int'(stg_vld), 0);
        chk(stg_bank_sel == '0, "R1 reset select", int'(stg_bank_sel), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue_en  = VEC[i][43];
            pc_adv    = VEC[i][42:39];
            redir_vld = VEC[i][38:35];
            redir_pc  = {NT{VEC[i][34:19]}};
            hv[i] = VEC[i][18];
            ht[i] = VEC[i][17:16];
            tick();
            chk(iss_vld == VEC[i][18], "R3 issue valid", int'(iss_vld), int'(VEC[i][18]));
            if (VEC[i][18]) begin
                chk(iss_tid == VEC[i][17:16], "R2 issue tid", int'(iss_tid), int'(VEC[i][17:16]));
                chk(iss_pc == VEC[i][15:0], "R5 R6 R7 issue pc", int'(iss_pc), int'(VEC[i][15:0]));
            end
            chk_stages(hv, ht, i);
        end

        // R1/R8: mid-run reset restores thread 0 first and base PCs.
        issue_en  = 1'b0;
        redir_vld = '0;
        rst_n     = 1'b0;
        tick();
        chk(stg_vld == '0, "R1 mid-run reset valid", int'(stg_vld), 0);
        rst_n    = 1'b1;
        issue_en = 1'b1;
        pc_adv   = '0;
        for (int t = 0; t < NT; t++) begin
            tick();
            chk(iss_tid == TW'(t), "R1 R2 post-reset tid", int'(iss_tid), t);
            chk(iss_pc == PW'(t * 'h100), "R8 post-reset pc", int'(iss_pc), t * 'h100);
        end
        // R6: advance bits cleared, so thread 0 reissues its base.
        tick();
        chk(iss_pc == 16'h0000, "R6 reissue same pc", int'(iss_pc), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(100_000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule